// File: doc/BRIEF.md
# Receive Mailbox Bank with Lowest-Free Allocation

This block keeps a bank of message mailboxes behind a CAN protocol engine. The engine hands over each frame it has already decoded (identifier, extended-format flag, remote-request flag, length code and eight data bytes) as a single-cycle strobe. The bank writes the frame into the lowest-numbered mailbox that is set up for reception and is able to take it, then raises that mailbox's ready flag. Frames are not queued in arrival order. A mailbox that has been filled stays full until the host re-arms it.

Each receive mailbox has a 3-bit mode. Mode 1 is plain receive: a full slot is skipped. Mode 2 is receive with overwrite: the slot accepts a new frame even while it still holds unread data, and it records the loss in a status bit. The host configures modes one mailbox at a time. It re-arms mailboxes with a write-one mask, which may name many mailboxes at once. It reads any mailbox through a combinational read port that returns an identifier word, a status word and the 64-bit payload. The ready flags are also collected into a vector and a maskable interrupt line. Only the lower `NUM_RX` of the `NUM_MB` mailboxes receive. The remaining slots belong to the transmit side and stay empty here.

Top module: `rxmb_bank`

## Requirements
- R1: After reset every mailbox is in mode 0 (off), every ready and lost flag is clear, `ready_vec`, `irq` and `drop_o` are 0, and every read-port word is 0.
- R2: A strobed frame is stored in the lowest-index mailbox that is eligible. Eligible means mode 1 with ready clear, or mode 2 whatever its ready state. The frame becomes visible on the ports after the clock edge that samples the strobe.
- R3: When no mailbox is eligible, the frame is discarded. `drop_o` is then high for exactly the one cycle after that edge, and no mailbox's contents or flags change.
- R4: A mode-1 mailbox whose ready flag is set keeps its contents when further frames arrive.
- R5: A mode-2 mailbox that receives a frame while ready sets its lost flag (status bit 24). When it receives a frame while empty, its lost flag is clear.
- R6: Reading a mailbox never clears its ready flag. Ready falls only on a re-arm or a mode write.
- R7: With `rearm_we` high, each set bit i of `rearm_bits` clears the ready and lost flags of mailbox i. Bits that are zero leave their mailboxes unchanged, and any number of bits may be set in one write.
- R8: The identifier word holds an extended identifier in bits 28:0 with bit 29 set. A standard identifier is held as `frm_id[10:0]` shifted left by 18 with bit 29 clear. Bits 31:30 are 0.
- R9: The status word has lost at bit 24, ready at bit 23, the remote flag at bit 20 and the length code in bits 19:16, with all other bits 0. `rd_data` returns the stored 64-bit payload.
- R10: `ready_vec[i]` equals mailbox i's ready flag, and `irq` is high exactly when some bit is set in both `ready_vec` and `irq_mask`.
- R11: Modes 0, 3 and 4 to 7 never receive. Mailboxes with index `NUM_RX` and above never receive, ignore mode writes and re-arms, and read as all zeros.
- R12: A mode write to a receive mailbox sets its mode and clears its ready and lost flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_idx | input | IDX_W | Mailbox addressed by the mode write |
| cfg_mode | input | 3 | New mode: 0 off, 1 receive, 2 receive with overwrite, 3 transmit |
| rearm_we | input | 1 | Re-arm strobe |
| rearm_bits | input | NUM_MB | Write-one mask of mailboxes to re-arm |
| frm_valid | input | 1 | Decoded frame strobe, one cycle per frame |
| frm_ide | input | 1 | Extended identifier flag |
| frm_rtr | input | 1 | Remote request flag |
| frm_id | input | 29 | Identifier (low 11 bits used for standard frames) |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload bytes |
| rd_idx | input | IDX_W | Mailbox selected for reading |
| rd_id | output | 32 | Identifier word of the selected mailbox |
| rd_status | output | 32 | Status word of the selected mailbox |
| rd_data | output | 64 | Payload of the selected mailbox |
| ready_vec | output | NUM_MB | Ready flag per mailbox |
| irq_mask | input | NUM_MB | Interrupt enable per mailbox |
| irq | output | 1 | Interrupt: some enabled mailbox is ready |
| drop_o | output | 1 | One-cycle pulse when a frame found no mailbox |

## Verification
The hardest situation to reach is the combination of a completely full bank and a full overwrite slot. To get there, every plain receive slot must be filled, the last slot must be moved out of overwrite mode, and then one more frame must arrive. Only then can the drop path and the "full slots are untouched" behaviour be seen. The directed phase drives the bank through exactly that sequence: it fills all slots in order, overruns the overwrite slot, reconfigures it, fills it again and sends one further frame. A random phase then mixes mode writes, partial re-arm masks and frames. That phase keeps pushing the bank between nearly empty and saturated, while a bench-side model predicts which slot each frame lands in.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int WORD_W = 32;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_OFF   = 3'd0;
    localparam logic [MODE_W-1:0] MODE_RX    = 3'd1;
    localparam logic [MODE_W-1:0] MODE_RXOVR = 3'd2;
    localparam logic [MODE_W-1:0] MODE_TX    = 3'd3;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              ready;
        logic              lost;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [WORD_W-1:0] idw;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic drop;
    } ctl_t;
endpackage

// File: rtl/rxmb_idfmt.sv
module rxmb_idfmt
    import rxmb_pkg::*;
(
    input  logic              ide,
    input  logic [ID_W-1:0]   id,
    output logic [WORD_W-1:0] idw
);
    localparam int STD_W     = 11;
    localparam int STD_SHIFT = ID_W - STD_W;

    always_comb begin
        idw = '0;
        if (ide) begin
            idw[ID_W-1:0] = id;
            idw[ID_W]     = 1'b1;
        end else begin
            idw[STD_SHIFT +: STD_W] = id[STD_W-1:0];
        end
    end
endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
    parameter int N = 12
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] onehot,
    output logic         hit
);
    // isolate lowest set bit: lowest index has highest priority
    assign onehot = elig & (~elig + N'(1));
    assign hit    = |elig;
endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
    import rxmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              rearm,
    input  logic              store,
    input  logic [WORD_W-1:0] idw,
    input  logic              rtr,
    input  logic [DLC_W-1:0]  dlc,
    input  logic [DATA_W-1:0] data,
    output slot_t             st_o
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (cfg_we) begin
            slot_d.mode  = cfg_mode;
            slot_d.ready = 1'b0;
            slot_d.lost  = 1'b0;
        end
        if (rearm) begin
            slot_d.ready = 1'b0;
            slot_d.lost  = 1'b0;
        end
        if (store) begin
            slot_d.lost  = slot_q.ready;
            slot_d.ready = 1'b1;
            slot_d.rtr   = rtr;
            slot_d.dlc   = dlc;
            slot_d.idw   = idw;
            slot_d.data  = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign st_o = slot_q;
endmodule

// File: rtl/rxmb_bank.sv
module rxmb_bank
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int NUM_RX = 12,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_mode,
    input  logic              rearm_we,
    input  logic [NUM_MB-1:0] rearm_bits,
    input  logic              frm_valid,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [28:0]       frm_id,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_id,
    output logic [31:0]       rd_status,
    output logic [63:0]       rd_data,
    output logic [NUM_MB-1:0] ready_vec,
    input  logic [NUM_MB-1:0] irq_mask,
    output logic              irq,
    output logic              drop_o
);
    slot_t             st [NUM_MB];
    logic [NUM_RX-1:0] elig;
    logic [NUM_RX-1:0] pick_oh;
    logic              pick_hit;
    logic [WORD_W-1:0] frm_idw;
    ctl_t              ctl_d, ctl_q;
    slot_t             sel;

    rxmb_idfmt u_idfmt (
        .ide (frm_ide),
        .id  (frm_id),
        .idw (frm_idw)
    );

    rxmb_pick #(.N(NUM_RX)) u_pick (
        .elig   (elig),
        .onehot (pick_oh),
        .hit    (pick_hit)
    );

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        if (i < NUM_RX) begin : g_rx
            assign elig[i] = ((st[i].mode == MODE_RX) && !st[i].ready) ||
                             (st[i].mode == MODE_RXOVR);
            rxmb_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_we   (cfg_we && (cfg_idx == IDX_W'(i))),
                .cfg_mode (cfg_mode),
                .rearm    (rearm_we && rearm_bits[i]),
                .store    (frm_valid && pick_oh[i]),
                .idw      (frm_idw),
                .rtr      (frm_rtr),
                .dlc      (frm_dlc),
                .data     (frm_data),
                .st_o     (st[i])
            );
        end else begin : g_tx
            // transmit-side slots: no receive storage in this bank
            assign st[i] = '0;
        end
        assign ready_vec[i] = st[i].ready;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.drop = frm_valid && !pick_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sel       = st[rd_idx];
    assign rd_id     = sel.idw;
    assign rd_data   = sel.data;
    assign rd_status = {7'd0, sel.lost, sel.ready, 2'd0, sel.rtr, sel.dlc, 16'd0};
    assign irq       = |(ready_vec & irq_mask);
    assign drop_o    = ctl_q.drop;
endmodule

// File: rtl/rxmb_bank_chk.sv
module rxmb_bank_chk #(
    parameter int NUM_MB = 16,
    parameter int NUM_RX = 12,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [2:0]        cfg_mode,
    input logic              rearm_we,
    input logic [NUM_MB-1:0] rearm_bits,
    input logic              frm_valid,
    input logic              frm_ide,
    input logic              frm_rtr,
    input logic [28:0]       frm_id,
    input logic [3:0]        frm_dlc,
    input logic [63:0]       frm_data,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [31:0]       rd_id,
    input logic [31:0]       rd_status,
    input logic [63:0]       rd_data,
    input logic [NUM_MB-1:0] ready_vec,
    input logic [NUM_MB-1:0] irq_mask,
    input logic              irq,
    input logic              drop_o
);
    a_r11_upper_never_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready_vec[NUM_MB-1:NUM_RX] == '0);

    a_r3_drop_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> $past(frm_valid));

    a_r3_drop_fills_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> ($countones(ready_vec) <= $countones($past(ready_vec))));

    a_r2_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ready_vec & ~$past(ready_vec)) <= 1);

    a_r7_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_we && !frm_valid) |=> ((ready_vec & $past(rearm_bits)) == '0));

    a_r6_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm_we && !cfg_we) |=> (($past(ready_vec) & ~ready_vec) == '0));

    a_r10_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready_vec != '0));
endmodule

bind rxmb_bank rxmb_bank_chk #(.NUM_MB(NUM_MB), .NUM_RX(NUM_RX)) u_chk (.*);

// File: tb/rxmb_bank_test.sv
module rxmb_bank_test;
    localparam int NMB = 16;
    localparam int NRX = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [2:0]  cfg_mode = '0;
    logic        rearm_we = 1'b0;
    logic [15:0] rearm_bits = '0;
    logic        frm_valid = 1'b0;
    logic        frm_ide = 1'b0;
    logic        frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_id, rd_status;
    logic [63:0] rd_data;
    logic [15:0] ready_vec;
    logic [15:0] irq_mask = '0;
    logic        irq, drop_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // 50 MHz: 20-unit period
    always #10 clk = ~clk;

    rxmb_bank uut (.*);

    // bench model
    logic [2:0]  m_mode [NRX];
    bit          m_rdy  [NRX];
    bit          m_lost [NRX];
    bit          m_rtr  [NRX];
    logic [3:0]  m_dlc  [NRX];
    logic [31:0] m_idw  [NRX];
    logic [63:0] m_data [NRX];
    bit          m_drop;

    function automatic logic [31:0] f_idw(input logic ide, input logic [28:0] id);
        return ide ? {3'b001, id} : {3'b000, id[10:0], 18'd0};
    endfunction

    function automatic bit f_elig(input int i);
        return (m_mode[i] == 3'd1 && !m_rdy[i]) || (m_mode[i] == 3'd2);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [15:0] exp_rv;
        exp_rv = '0;
        for (int i = 0; i < NRX; i++) exp_rv[i] = m_rdy[i];
        chk({tag, " R3 drop_o"}, 64'(drop_o), 64'(m_drop));
        chk({tag, " R10 ready_vec"}, 64'(ready_vec), 64'(exp_rv));
        chk({tag, " R10 irq"}, 64'(irq), 64'(|(exp_rv & irq_mask)));
        for (int i = 0; i < NMB; i++) begin
            logic [31:0] e_id, e_st;
            logic [63:0] e_dt;
            rd_idx = 4'(i);
            #1;
            if (i < NRX) begin
                e_id = m_idw[i];
                e_st = {7'd0, m_lost[i], m_rdy[i], 2'd0, m_rtr[i], m_dlc[i], 16'd0};
                e_dt = m_data[i];
            end else begin
                e_id = '0; e_st = '0; e_dt = '0;
            end
            chk($sformatf("%s R8 id mb%0d", tag, i), 64'(rd_id), 64'(e_id));
            chk($sformatf("%s R9 status mb%0d", tag, i), 64'(rd_status), 64'(e_st));
            chk($sformatf("%s R9 data mb%0d", tag, i), rd_data, e_dt);
        end
    endtask

    task automatic step(input bit fv, input bit ide, input bit rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [63:0] dat,
                        input bit rw, input logic [15:0] rb,
                        input bit cw, input logic [3:0] ci, input logic [2:0] cm,
                        input logic [15:0] msk, input string tag);
        int pick;
        bit old_rdy;
        pick = -1;
        if (fv) for (int i = 0; i < NRX; i++) if (pick < 0 && f_elig(i)) pick = i;
        old_rdy = (pick >= 0) ? m_rdy[pick] : 1'b0;
        @(negedge clk);
        frm_valid = fv; frm_ide = ide; frm_rtr = rtr; frm_id = id; frm_dlc = dlc; frm_data = dat;
        rearm_we = rw; rearm_bits = rb; cfg_we = cw; cfg_idx = ci; cfg_mode = cm; irq_mask = msk;
        @(posedge clk);
        #2;
        frm_valid = 0; rearm_we = 0; cfg_we = 0;
        if (cw && ci < NRX) begin
            m_mode[ci] = cm; m_rdy[ci] = 0; m_lost[ci] = 0;
        end
        if (rw) for (int i = 0; i < NRX; i++) if (rb[i]) begin m_rdy[i] = 0; m_lost[i] = 0; end
        if (fv && pick >= 0) begin
            m_lost[pick] = old_rdy; m_rdy[pick] = 1; m_rtr[pick] = rtr;
            m_dlc[pick] = dlc; m_idw[pick] = f_idw(ide, id); m_data[pick] = dat;
        end
        m_drop = fv && (pick < 0);
        compare_all(tag);
    endtask

    task automatic frame(input bit ide, input logic [28:0] id, input logic [15:0] msk, input string tag);
        step(1, ide, id[0], id, id[3:0], {id[27:0], 36'h5A5A0C3C1}, 0, 0, 0, 0, 0, msk, tag);
    endtask

    initial begin
        for (int i = 0; i < NRX; i++) begin
            m_mode[i] = 0; m_rdy[i] = 0; m_lost[i] = 0; m_rtr[i] = 0;
            m_dlc[i] = 0; m_idw[i] = 0; m_data[i] = 0;
        end
        m_drop = 0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        compare_all("R1 reset");
        // configure: 0..10 plain receive, 11 overwrite
        for (int i = 0; i < NRX; i++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'(i), (i == NRX-1) ? 3'd2 : 3'd1, 16'hFFFF, "R12 cfg");
        // fill in index order, alternating identifier formats
        for (int i = 0; i < NRX; i++)
            frame(i[0], 29'h1ABC_0000 + 29'(i * 37), 16'h0001, "R2 fill");
        frame(1, 29'h0F0F_F0F0, 16'h0800, "R5 overwrite");
        frame(0, 29'h0000_07FF, 16'h0800, "R5 overwrite twice");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd11, 3'd1, 16'h0000, "R12 mode clears");
        frame(0, 29'h0000_0123, 16'h0000, "R2 refill");
        frame(1, 29'h1234_5678, 16'h0000, "R3 drop full");
        frame(0, 29'h0000_0456, 16'h0000, "R4 no overwrite");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0000, "R6 read keeps");
        step(0, 0, 0, 0, 0, 0, 1, 16'h00FF, 0, 0, 0, 16'h0100, "R7 rearm low");
        step(0, 0, 0, 0, 0, 0, 1, 16'h0000, 0, 0, 0, 16'h0100, "R7 zero mask");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd13, 3'd1, 16'h0100, "R11 upper cfg");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd0, 3'd3, 16'h0100, "R11 tx mode");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd1, 3'd6, 16'h0100, "R11 mode6");
        frame(1, 29'h1FFF_FFFF, 16'h0004, "R11 skip");
        frame(0, 29'h0000_0001, 16'h0008, "R2 next");
        step(0, 0, 0, 0, 0, 0, 1, 16'hF000, 0, 0, 0, 16'hF000, "R11 upper rearm");
        // random phase
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [2:0] modes [8];
            modes = '{3'd0, 3'd1, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd5};
            op = $urandom_range(0, 9);
            if (op < 6)
                step(1, 1'($urandom), 1'($urandom), 29'($urandom), 4'($urandom),
                     {$urandom, $urandom}, 0, 0, 0, 0, 0, 16'($urandom), "R2 rnd frame");
            else if (op < 8)
                step($urandom_range(0, 3) == 0, 1'($urandom), 0, 29'($urandom), 4'($urandom),
                     {$urandom, $urandom}, 1, 16'($urandom) & 16'($urandom), 0, 0, 0,
                     16'($urandom), "R7 rnd rearm");
            else
                step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'($urandom), modes[$urandom_range(0, 7)],
                     16'($urandom), "R12 rnd cfg");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule